// File: doc/BRIEF.md
# Vector Carry-Less Multiply-Long Unit

This block is the widening polynomial multiply datapath of a SIMD unit. Partial products are combined with XOR, so there are no carries between bit positions. Two 128-bit source vectors arrive together with an element-size code and a half select, and the unit returns one 128-bit destination vector.

The element-size code picks one of two modes:

- **Byte mode:** eight independent 8x8 products, each widened into its own 16-bit lane.
- **64-bit mode:** a single 64x64 product that fills all 128 result bits.

The half select chooses which 64-bit half of both sources supplies the operands. A valid-in/valid-out handshake with a fixed one-cycle latency carries each operation through a single register stage.

Top module: `pmul_unit`

## Requirements
- R1: With `elem_size` = 0 (byte mode), result lane k (bits 16k+15..16k, k = 0..7) holds the carry-less product of byte k of the selected half of `src_a` and byte k of the selected half of `src_b`.
- R2: With `elem_size` = 3 (64-bit mode), the 128-bit result is the carry-less product of the selected 64-bit doubleword of `src_a` and that of `src_b`.
- R3: With `upper_half` = 0, operands come from bits 63..0 of each source, which are bytes 0..7 or doubleword 0.
- R4: With `upper_half` = 1, operands come from bits 127..64 of each source, which are bytes 8..15 or doubleword 1. Result lanes are still filled from lane 0 upward.
- R5: With `elem_size` = 1 or 2, `illegal` is 1 and the result is all zeros. For codes 0 and 3, `illegal` is 0.
- R6: Bit 15 of every lane in byte mode, and bit 127 in 64-bit mode, is always 0.
- R7: The outputs for an operation appear with `out_valid` = 1 exactly one cycle after `in_valid` = 1. `out_valid` is 0 in a cycle that follows a cycle without `in_valid`. A synchronous active-high `rst` clears `out_valid`.
- R8: A shift of zero passes the operand through, so an operand with only bit i set yields the other operand shifted left by i. In 64-bit mode, bits shifted past bit 63 land in the upper doubleword. A zero operand yields a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| elem_size | input | 2 | 0 = byte lanes, 3 = 64-bit; 1 and 2 are illegal |
| upper_half | input | 1 | 0 = lower 64 bits of sources, 1 = upper 64 bits |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 128 | Widened carry-less product(s) |
| illegal | output | 1 | Unsupported element-size code was issued |

## Verification
Every result of this unit, including the illegal flag, is due on the rising edge that directly follows the edge at which its inputs were taken. The driver applies inputs half a cycle before that capture edge and queues the expected value, computed bit by bit. The monitor samples just after each rising edge, so a queued item must be matched by `out_valid` at exactly that edge and by no other. Idle gaps between operations then confirm that `out_valid` drops in the cycle after an idle input.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

  typedef enum logic [1:0] {
    ESZ_BYTE = 2'd0,
    ESZ_HALF = 2'd1,
    ESZ_WORD = 2'd2,
    ESZ_DBL  = 2'd3
  } esize_e;

endpackage

// File: rtl/pmul_half_sel.sv
module pmul_half_sel #(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0]   vec_a,
  input  logic [VEC_W-1:0]   vec_b,
  input  logic               hi_sel,
  output logic [VEC_W/2-1:0] half_a,
  output logic [VEC_W/2-1:0] half_b
);
  localparam int HALF_W = VEC_W / 2;

  always_comb begin
    if (hi_sel) begin
      half_a = vec_a[VEC_W-1:HALF_W];
      half_b = vec_b[VEC_W-1:HALF_W];
    end else begin
      half_a = vec_a[HALF_W-1:0];
      half_b = vec_b[HALF_W-1:0];
    end
  end
endmodule

// File: rtl/pmul_clmul.sv
module pmul_clmul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [PW-1:0] acc [W+1];
  logic [PW-1:0] opb_wide;

  assign opb_wide = {{W{1'b0}}, opb};
  assign acc[0]   = '0;

  for (genvar i = 0; i < W; i++) begin : g_row
    assign acc[i+1] = acc[i] ^ (opa[i] ? (opb_wide << i) : {PW{1'b0}});
  end

  assign prod = acc[W];
endmodule

// File: rtl/pmul_unit.sv
module pmul_unit
  import pmul_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int SEW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [1:0]       elem_size,
  input  logic             upper_half,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             illegal
);
  localparam int HALF_W = VEC_W / 2;
  localparam int LANES  = HALF_W / SEW_W;
  localparam int LANE_W = 2 * SEW_W;

  logic [HALF_W-1:0] op_a, op_b;
  logic [VEC_W-1:0]  byte_res, dbl_res, next_res;
  logic              next_ill;
  esize_e            esz;

  assign esz = esize_e'(elem_size);

  pmul_half_sel #(.VEC_W(VEC_W)) u_sel (
    .vec_a (src_a),
    .vec_b (src_b),
    .hi_sel(upper_half),
    .half_a(op_a),
    .half_b(op_b)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pmul_clmul #(.W(SEW_W)) u_lane (
      .opa (op_a[k*SEW_W +: SEW_W]),
      .opb (op_b[k*SEW_W +: SEW_W]),
      .prod(byte_res[k*LANE_W +: LANE_W])
    );
  end

  pmul_clmul #(.W(HALF_W)) u_dbl (
    .opa (op_a),
    .opb (op_b),
    .prod(dbl_res)
  );

  always_comb begin
    next_res = '0;
    next_ill = 1'b0;
    unique case (esz)
      ESZ_BYTE: next_res = byte_res;
      ESZ_DBL:  next_res = dbl_res;
      default:  next_ill = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid & next_ill;
      if (in_valid) result <= next_res;
    end
  end
endmodule

// File: rtl/pmul_unit_chk.sv
module pmul_unit_chk #(
  parameter int VEC_W = 128,
  parameter int SEW_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [VEC_W-1:0] src_a,
  input logic [1:0]       elem_size,
  input logic             out_valid,
  input logic [VEC_W-1:0] result,
  input logic             illegal
);
  localparam int LANE_W = 2 * SEW_W;
  localparam int LANES  = VEC_W / LANE_W;

  logic [VEC_W-1:0] lane_top_mask;
  always_comb begin
    lane_top_mask = '0;
    for (int k = 0; k < LANES; k++) lane_top_mask[k*LANE_W + LANE_W - 1] = 1'b1;
  end

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r7_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r5_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (elem_size == 2'd1 || elem_size == 2'd2)) |=> (illegal && result == '0));

  a_r5_legal_clear: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (elem_size == 2'd0 || elem_size == 2'd3)) |=> !illegal);

  a_r5_illegal_with_valid: assert property (@(posedge clk) disable iff (rst)
    illegal |-> out_valid);

  a_r6_byte_top_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && elem_size == 2'd0) |=> ((result & lane_top_mask) == '0));

  a_r6_dbl_top_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && elem_size == 2'd3) |=> !result[VEC_W-1]);

  a_r8_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_a == '0) |=> (result == '0));
endmodule

bind pmul_unit pmul_unit_chk #(.VEC_W(VEC_W), .SEW_W(SEW_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .src_a    (src_a),
  .elem_size(elem_size),
  .out_valid(out_valid),
  .result   (result),
  .illegal  (illegal)
);

// File: tb/pmul_unit_bench.sv
module pmul_unit_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic [1:0]   elem_size = '0;
  logic         upper_half = 1'b0;
  logic         out_valid;
  logic [127:0] result;
  logic         illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [127:0] q_res[$];
  logic         q_ill[$];
  string        q_tag[$];

  always #2.5 clk = ~clk;

  pmul_unit u_pmul_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .elem_size(elem_size), .upper_half(upper_half),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  function automatic logic [127:0] ref_model(input logic [127:0] a, input logic [127:0] b,
                                             input logic [1:0] sz, input logic hi);
    logic [127:0] r;
    logic [63:0]  ha, hb;
    r  = '0;
    ha = hi ? a[127:64] : a[63:0];
    hb = hi ? b[127:64] : b[63:0];
    if (sz == 2'd0) begin
      for (int k = 0; k < 8; k++) begin
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++)
          if (ha[8*k+i]) p = p ^ ({8'h00, hb[8*k +: 8]} << i);
        r[16*k +: 16] = p;
      end
    end else if (sz == 2'd3) begin
      for (int i = 0; i < 64; i++)
        if (ha[i]) r = r ^ ({64'h0, hb} << i);
    end
    return r;
  endfunction

  task automatic issue(input logic [127:0] a, input logic [127:0] b,
                       input logic [1:0] sz, input logic hi, input string tag);
    @(negedge clk);
    src_a = a; src_b = b; elem_size = sz; upper_half = hi; in_valid = 1'b1;
    q_res.push_back(ref_model(a, b, sz, hi));
    q_ill.push_back(sz == 2'd1 || sz == 2'd2);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src_a = '0; src_b = '0;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Monitor: samples 1 ns after each rising edge.
  initial begin
    @(negedge rst);
    forever begin
      @(posedge clk);
      #1;
      checks++;
      if (out_valid !== (q_res.size() > 0)) begin
        fails++;
        $display("FAIL R7: out_valid=%0b expected %0b", out_valid, q_res.size() > 0);
      end
      if (q_res.size() > 0) begin
        logic [127:0] er;
        logic         ei;
        string        t;
        er = q_res.pop_front();
        ei = q_ill.pop_front();
        t  = q_tag.pop_front();
        checks++;
        if (result !== er || illegal !== ei) begin
          fails++;
          $display("FAIL %s: result=%h illegal=%0b expected %h %0b", t, result, illegal, er, ei);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    logic [127:0] ra, rb;
    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || illegal !== 1'b0) begin
      fails++;
      $display("FAIL R7: reset out_valid=%0b illegal=%0b expected 0 0", out_valid, illegal);
    end
    @(negedge clk);
    rst = 1'b0;

    // R8 zero operands
    issue('0, {128{1'b1}}, 2'd0, 1'b0, "R8 zero byte");
    issue({128{1'b1}}, '0, 2'd3, 1'b1, "R8 zero dbl");
    // R6 all ones, both modes, both halves
    issue({128{1'b1}}, {128{1'b1}}, 2'd0, 1'b0, "R6 R1 R3 ones byte lo");
    issue({128{1'b1}}, {128{1'b1}}, 2'd0, 1'b1, "R6 R1 R4 ones byte hi");
    issue({128{1'b1}}, {128{1'b1}}, 2'd3, 1'b0, "R6 R2 R3 ones dbl lo");
    issue({128{1'b1}}, {128{1'b1}}, 2'd3, 1'b1, "R6 R2 R4 ones dbl hi");
    idle(2);
    // R3/R4 distinct halves
    issue({64'hFEDCBA9876543210, 64'h0123456789ABCDEF},
          {64'h1111111122222222, 64'h0F0F0F0F80808080}, 2'd0, 1'b0, "R3 byte lo");
    issue({64'hFEDCBA9876543210, 64'h0123456789ABCDEF},
          {64'h1111111122222222, 64'h0F0F0F0F80808080}, 2'd0, 1'b1, "R4 byte hi");
    issue({64'hFEDCBA9876543210, 64'h0123456789ABCDEF},
          {64'h1111111122222222, 64'h0F0F0F0F80808080}, 2'd3, 1'b0, "R3 dbl lo");
    issue({64'hFEDCBA9876543210, 64'h0123456789ABCDEF},
          {64'h1111111122222222, 64'h0F0F0F0F80808080}, 2'd3, 1'b1, "R4 dbl hi");
    // R5 illegal codes
    issue({128{1'b1}}, {128{1'b1}}, 2'd1, 1'b0, "R5 size1");
    idle(1);
    issue({128{1'b1}}, {128{1'b1}}, 2'd2, 1'b1, "R5 size2");
    // R8 single-bit operand, carry across doubleword boundary
    for (int i = 0; i < 64; i++) begin
      issue({64'h0, 64'h1 << i}, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, 2'd3, 1'b0, "R8 single bit dbl lo");
      issue({64'h1 << i, 64'h0}, {64'hA5A5_0F0F_C3C3_8001, 64'h0}, 2'd3, 1'b1, "R8 single bit dbl hi");
    end
    for (int i = 0; i < 8; i++) begin
      issue({16{8'h01 << i}}, {16{8'hFF}}, 2'd0, i[0], "R8 R1 single bit byte");
    end
    idle(3);
    // R1/R2 pseudo-random mix
    for (int n = 0; n < 200; n++) begin
      ra = {$urandom(), $urandom(), $urandom(), $urandom()};
      rb = {$urandom(), $urandom(), $urandom(), $urandom()};
      issue(ra, rb, (n % 3 == 0) ? 2'd0 : 2'd3, n[1], "R1 R2 random");
      if (n % 17 == 0) idle(1);
    end
    idle(4);
    summary();
  end
endmodule